// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a bank of 32-bit status and control words. It sits on a plain synchronous read/write port that addresses a 4 KB window by byte offset. Software uses it to read a board identification word and a processor identification word, to drive an LED register, and to keep two scratch configuration words. It also uses it to maintain two flag sets: one volatile and one that survives a system reset. Each flag set has its own set address and its own clear address.

A reset-level register can be written only after software has stored a 16-bit key in a lock register. When an accepted write to the reset-level register has bit 8 set, the block emits a one-cycle request that asks the surrounding system for a reset. A third register samples two external lines: card presence and write protect. The bit that carries write protect depends on the board type coded in the identification word. Fixed words return constant values, and every other offset reads as zero and ignores writes.

Two reset inputs are provided. `rst_n` is the system reset, which the non-volatile flags survive. `por_n` is the power-on reset, which clears everything.

Top module: `sysreg_bank`

## Requirements
- R1: While `rst_n` or `por_n` is low, the block clears the LED word, the lock word, both configuration words, the volatile flags, the reset level and `reset_req_o` at the next clock edge. Only `por_n` low clears the non-volatile flags.
- R2: A write to offset 0x20 whose full 32-bit data equals 0x0000A05F stores 0xA05F. Any other write stores data bits 15:0 with bit 15 forced to 0. The lock word reads zero-extended at 0x20. The bank is unlocked only while the lock word equals 0xA05F.
- R3: A write to offset 0x40 changes the reset level only while the bank is unlocked. Such a write with data bit 8 set makes `reset_req_o` high for exactly the one cycle after the write edge. A write made while locked leaves the reset level unchanged and gives no pulse.
- R4: A write to 0x30 ORs the data into the volatile flags, and a write to 0x34 clears each flag whose data bit is 1. The flags read at 0x30, and offset 0x34 reads zero.
- R5: The non-volatile flags use 0x38 for set and read and 0x3C for clear, with the same rules as R4. They keep their value through `rst_n`.
- R6: When bits 27:16 of `ID_WORD` equal 0x190, offset 0x40 reads zero, ignores writes and never raises `reset_req_o`.
- R7: At offset 0x48, bit 0 equals `card_det` as sampled at the previous clock edge. `card_wp`, sampled the same way, appears in bit 2 when the board type is 0x100 or 0x140 and in bit 1 otherwise. All other bits are zero, and writes to this offset are ignored.
- R8: Offset 0x00 reads `ID_WORD` and 0x84 reads `PROC_WORD`. Offset 0x44 reads 1, 0x50 reads 0x1000 and 0x88 reads 0xFF000000, and writes to these offsets are ignored.
- R9: Offsets 0x08, 0x28 and 0x2C are read/write words. Any offset not named in R2 to R9 reads zero and ignores writes. Address bits 1:0 are ignored, and read data is combinational from `bus_addr`.
- R10: `led_o` always equals the LED word held at offset 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears all state |
| rst_n | input | 1 | System reset, active low, synchronous, spares the non-volatile flags |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| card_det | input | 1 | Card presence line |
| card_wp | input | 1 | Card write-protect line |
| led_o | output | 32 | LED register contents |
| reset_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `card_det` and `card_wp` are synchronous to `clk`. They also assume that a write holds `bus_addr` and `bus_wdata` steady for the edge at which `bus_sel` and `bus_wr` are high. The stimulus changes every input only on the falling edge and keeps the card lines still while it sweeps reads. It also keeps one write per access, so the set and clear addresses are never hit in the same cycle. Because of this, the flag assertions can rely on one operation per edge.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int WIN_AW  = 12;
    localparam int WORD_AW = WIN_AW - 2;

    // word indices (byte offset / 4)
    localparam logic [WORD_AW-1:0] W_IDENT  = 10'h000;
    localparam logic [WORD_AW-1:0] W_LEDS   = 10'h002;
    localparam logic [WORD_AW-1:0] W_LOCK   = 10'h008;
    localparam logic [WORD_AW-1:0] W_SCR0   = 10'h00A;
    localparam logic [WORD_AW-1:0] W_SCR1   = 10'h00B;
    localparam logic [WORD_AW-1:0] W_VSET   = 10'h00C;
    localparam logic [WORD_AW-1:0] W_VCLR   = 10'h00D;
    localparam logic [WORD_AW-1:0] W_NSET   = 10'h00E;
    localparam logic [WORD_AW-1:0] W_NCLR   = 10'h00F;
    localparam logic [WORD_AW-1:0] W_RLVL   = 10'h010;
    localparam logic [WORD_AW-1:0] W_PCIC   = 10'h011;
    localparam logic [WORD_AW-1:0] W_CARD   = 10'h012;
    localparam logic [WORD_AW-1:0] W_LCDC   = 10'h014;
    localparam logic [WORD_AW-1:0] W_CPUA   = 10'h021;
    localparam logic [WORD_AW-1:0] W_CPUB   = 10'h022;

    localparam logic [31:0] UNLOCK_KEY   = 32'h0000_A05F;
    localparam logic [31:0] K_PCIC       = 32'h0000_0001;
    localparam logic [31:0] K_LCDC       = 32'h0000_1000;
    localparam logic [31:0] K_CPUB       = 32'hFF00_0000;

    localparam logic [11:0] BT_NO_RLVL   = 12'h190;
    localparam logic [11:0] BT_WP_HIGH_A = 12'h100;
    localparam logic [11:0] BT_WP_HIGH_B = 12'h140;

    localparam int CARD_W   = 3;
    localparam int REQ_BIT  = 8;

    typedef struct packed {
        logic [31:0]       leds;
        logic [31:0]       scr0;
        logic [31:0]       scr1;
        logic [31:0]       rlvl;
        logic [CARD_W-1:0] card;
        logic              req;
    } ctl_state_t;

endpackage

// File: rtl/sysreg_lock.sv
module sysreg_lock
    import sysreg_pkg::*;
#(
    parameter int          LOCK_W = 16,
    parameter logic [31:0] KEY    = UNLOCK_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [LOCK_W-1:0] lock_q,
    output logic              unlocked
);
    localparam logic [LOCK_W-1:0] KEY_LO   = KEY[LOCK_W-1:0];
    localparam logic [LOCK_W-1:0] TOP_MASK = {1'b0, {(LOCK_W-1){1'b1}}};

    logic [LOCK_W-1:0] lock_d;

    always_comb begin
        lock_d = lock_q;
        if (wr_en) begin
            if (wdata == KEY) lock_d = KEY_LO;
            else              lock_d = wdata[LOCK_W-1:0] & TOP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign unlocked = (lock_q == KEY_LO);

    // R2: unlocking happens only through an exact key write
    a_r2_key_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && (wdata == KEY)));

    // R2: a non-key write always leaves the top bit clear
    a_r2_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata != KEY)) |=> !lock_q[LOCK_W-1]);

endmodule

// File: rtl/sysreg_setclr.sv
module sysreg_setclr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d;

    always_comb begin
        q_d = q;
        if (set_en) q_d = q_d | wdata;
        if (clr_en) q_d = q_d & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end

    // R4: every bit named in a set write is 1 afterwards
    a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en) |=> ((q & $past(wdata)) == $past(wdata)));

    // R4: every bit named in a clear write is 0 afterwards
    a_r4_clr_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(wdata)) == '0));

    // R5: without a set or clear the value holds (across system reset for the retained bank)
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(q));

endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux
    import sysreg_pkg::*;
#(
    parameter logic [31:0] ID_WORD   = 32'h0178_0000,
    parameter logic [31:0] PROC_WORD = 32'h0C00_0000,
    parameter bit          RLVL_VIS  = 1'b1
) (
    input  logic [WORD_AW-1:0] waddr,
    input  logic [31:0]        leds,
    input  logic [15:0]        lock,
    input  logic [31:0]        scr0,
    input  logic [31:0]        scr1,
    input  logic [31:0]        vflags,
    input  logic [31:0]        nflags,
    input  logic [31:0]        rlvl,
    input  logic [CARD_W-1:0]  card,
    output logic [31:0]        rdata
);
    logic [31:0] rlvl_view;

    generate
        if (RLVL_VIS) begin : g_rlvl_on
            assign rlvl_view = rlvl;
        end else begin : g_rlvl_off
            assign rlvl_view = '0;
        end
    endgenerate

    always_comb begin
        unique case (waddr)
            W_IDENT: rdata = ID_WORD;
            W_LEDS:  rdata = leds;
            W_LOCK:  rdata = {16'h0000, lock};
            W_SCR0:  rdata = scr0;
            W_SCR1:  rdata = scr1;
            W_VSET:  rdata = vflags;
            W_NSET:  rdata = nflags;
            W_RLVL:  rdata = rlvl_view;
            W_PCIC:  rdata = K_PCIC;
            W_CARD:  rdata = {{(32-CARD_W){1'b0}}, card};
            W_LCDC:  rdata = K_LCDC;
            W_CPUA:  rdata = PROC_WORD;
            W_CPUB:  rdata = K_CPUB;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter logic [31:0] ID_WORD   = 32'h0178_0000,
    parameter logic [31:0] PROC_WORD = 32'h0C00_0000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              card_det,
    input  logic              card_wp,
    output logic [31:0]       led_o,
    output logic              reset_req_o
);
    localparam logic [11:0] BOARD   = ID_WORD[27:16];
    localparam bit          RLVL_EN = (BOARD != BT_NO_RLVL);
    localparam bit          WP_HIGH = (BOARD == BT_WP_HIGH_A) || (BOARD == BT_WP_HIGH_B);

    ctl_state_t s_d, s_q;

    logic               sys_rst_n;
    logic               wr;
    logic [WORD_AW-1:0] waddr;
    logic [15:0]        lock_word;
    logic               unlocked;
    logic [31:0]        vflags;
    logic [31:0]        nflags;
    logic [CARD_W-1:0]  card_sample;

    assign sys_rst_n = rst_n & por_n;
    assign wr        = bus_sel & bus_wr;
    assign waddr     = bus_addr[WIN_AW-1:2];

    generate
        if (WP_HIGH) begin : g_wp_hi
            assign card_sample = {card_wp, 1'b0, card_det};
        end else begin : g_wp_lo
            assign card_sample = {1'b0, card_wp, card_det};
        end
    endgenerate

    sysreg_lock #(.LOCK_W(16), .KEY(UNLOCK_KEY)) u_lock (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .wr_en    (wr && (waddr == W_LOCK)),
        .wdata    (bus_wdata),
        .lock_q   (lock_word),
        .unlocked (unlocked)
    );

    sysreg_setclr #(.W(32)) u_vflags (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .set_en (wr && (waddr == W_VSET)),
        .clr_en (wr && (waddr == W_VCLR)),
        .wdata  (bus_wdata),
        .q      (vflags)
    );

    sysreg_setclr #(.W(32)) u_nflags (
        .clk    (clk),
        .rst_n  (por_n),
        .set_en (wr && (waddr == W_NSET)),
        .clr_en (wr && (waddr == W_NCLR)),
        .wdata  (bus_wdata),
        .q      (nflags)
    );

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        s_d.card = card_sample;
        if (wr) begin
            unique case (waddr)
                W_LEDS: s_d.leds = bus_wdata;
                W_SCR0: s_d.scr0 = bus_wdata;
                W_SCR1: s_d.scr1 = bus_wdata;
                W_RLVL: begin
                    if (RLVL_EN && unlocked) begin
                        s_d.rlvl = bus_wdata;
                        s_d.req  = bus_wdata[REQ_BIT];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!sys_rst_n) s_q <= '0;
        else            s_q <= s_d;
    end

    sysreg_rdmux #(.ID_WORD(ID_WORD), .PROC_WORD(PROC_WORD), .RLVL_VIS(RLVL_EN)) u_rdmux (
        .waddr  (waddr),
        .leds   (s_q.leds),
        .lock   (lock_word),
        .scr0   (s_q.scr0),
        .scr1   (s_q.scr1),
        .vflags (vflags),
        .nflags (nflags),
        .rlvl   (s_q.rlvl),
        .card   (s_q.card),
        .rdata  (bus_rdata)
    );

    assign led_o       = s_q.leds;
    assign reset_req_o = s_q.req;

    // R3: a request only follows a cycle in which the key was held
    a_r3_req_keyed: assert property (@(posedge clk) disable iff (!sys_rst_n)
        reset_req_o |-> $past(lock_word == UNLOCK_KEY[15:0]));

    // R3: while locked the reset level cannot move
    a_r3_locked_hold: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !unlocked |=> $stable(s_q.rlvl));

    // R6: boards without reset control never request
    a_r6_no_req: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !RLVL_EN |-> !reset_req_o);

    // R7: bit 0 of the card word follows the presence line one edge later
    a_r7_card_follow: assert property (@(posedge clk) disable iff (!sys_rst_n)
        1'b1 |=> (s_q.card[0] == $past(card_det)));

    // R10: LED pins change only on a write to the LED word
    a_r10_led_write: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !(wr && (waddr == W_LEDS)) |=> $stable(led_o));

endmodule

// File: tb/tb_sysreg_bank.sv
`timescale 1ns/1ps
module tb_sysreg_bank;

    localparam logic [31:0] ID_GEN  = 32'h0178_0000;
    localparam logic [31:0] ID_NORL = 32'h0190_0000;
    localparam logic [31:0] ID_WPHI = 32'h0140_0000;
    localparam logic [31:0] PROC    = 32'h0C00_0091;

    logic        clk = 1'b0;
    logic        por_n, rst_n, bus_sel, bus_wr, card_det, card_wp;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] rd_a, rd_b, rd_c, led_a, led_b, led_c;
    logic        req_a, req_b, req_c;

    int n_chk = 0;
    int n_bad = 0;

    // model of the generic instance
    logic [31:0] m_led, m_scr0, m_scr1, m_vf, m_nf, m_rl;
    logic [15:0] m_lock;

    always #4 clk = ~clk;

    sysreg_bank #(.ID_WORD(ID_GEN), .PROC_WORD(PROC)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a),
        .card_det(card_det), .card_wp(card_wp), .led_o(led_a), .reset_req_o(req_a));

    sysreg_bank #(.ID_WORD(ID_NORL), .PROC_WORD(PROC)) dut_norl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
        .card_det(card_det), .card_wp(card_wp), .led_o(led_b), .reset_req_o(req_b));

    sysreg_bank #(.ID_WORD(ID_WPHI), .PROC_WORD(PROC)) dut_wphi (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_c),
        .card_det(card_det), .card_wp(card_wp), .led_o(led_c), .reset_req_o(req_c));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int w);
        case (w)
            'h000: return ID_GEN;
            'h002: return m_led;
            'h008: return {16'h0, m_lock};
            'h00A: return m_scr0;
            'h00B: return m_scr1;
            'h00C: return m_vf;
            'h00E: return m_nf;
            'h010: return m_rl;
            'h011: return 32'h1;
            'h012: return {30'h0, card_wp, card_det};
            'h014: return 32'h1000;
            'h021: return PROC;
            'h022: return 32'hFF00_0000;
            default: return 32'h0;
        endcase
    endfunction

    // applies a write to the model; returns the expected request
    function automatic logic model_wr(input int w, input logic [31:0] d);
        logic rq;
        rq = 1'b0;
        case (w)
            'h002: m_led  = d;
            'h008: m_lock = (d == 32'h0000_A05F) ? 16'hA05F : (d[15:0] & 16'h7FFF);
            'h00A: m_scr0 = d;
            'h00B: m_scr1 = d;
            'h00C: m_vf   = m_vf | d;
            'h00D: m_vf   = m_vf & ~d;
            'h00E: m_nf   = m_nf | d;
            'h00F: m_nf   = m_nf & ~d;
            'h010: if (m_lock == 16'hA05F) begin m_rl = d; rq = d[8]; end
            default: ;
        endcase
        return rq;
    endfunction

    function automatic void model_sysrst();
        m_led = '0; m_lock = '0; m_scr0 = '0; m_scr1 = '0; m_vf = '0; m_rl = '0;
    endfunction

    // write; returns the request levels seen during the following cycle
    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      output logic ra, output logic rb, output logic rc);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        ra = req_a; rb = req_b; rc = req_c;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
    endtask

    task automatic mwr(input string tag, input logic [11:0] a, input logic [31:0] d);
        logic ra, rb, rc, e;
        e = model_wr(int'(a[11:2]), d);
        wr(a, d, ra, rb, rc);
        chk(tag, {31'h0, ra}, {31'h0, e});
    endtask

    task automatic sweep_rd(input string tag);
        for (int w = 0; w < 1024; w++) begin
            rd(12'(w * 4));
            chk(tag, rd_a, exp_rd(w));
        end
    endtask

    task automatic sweep_wr(input string tag, input logic [31:0] seed);
        for (int w = 0; w < 1024; w++) begin
            logic [31:0] d;
            d = (seed * 32'(w + 1)) ^ 32'(w << 7) ^ 32'h5A5A_0F0F;
            mwr(tag, 12'(w * 4), d);
        end
    endtask

    initial begin
        logic ra, rb, rc;
        por_n = 1'b0; rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0; card_det = 1'b0; card_wp = 1'b0;
        model_sysrst(); m_nf = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        #1;
        chk("R1 req after reset", {31'h0, req_a}, 32'h0);
        sweep_rd("R1 R8 R9 reset sweep");

        // pass 1: presence high, protect low; R4 R5 R8 R9 R10 via full sweep
        card_det = 1'b1; card_wp = 1'b0;
        mwr("R2 unlock", 12'h020, 32'h0000_A05F);
        sweep_wr("R9 R3 write sweep 1", 32'h9E37_79B9);
        sweep_rd("R9 R4 R5 R7 read sweep 1");
        chk("R10 led pins", led_a, m_led);

        // pass 2: presence low, protect high
        card_det = 1'b0; card_wp = 1'b1;
        mwr("R2 unlock", 12'h020, 32'h0000_A05F);
        sweep_wr("R9 R3 write sweep 2", 32'h85EB_CA6B);
        sweep_rd("R9 R4 R5 R7 read sweep 2");
        chk("R10 led pins", led_a, m_led);

        // R2 lock encodings
        mwr("R2 wide key", 12'h020, 32'h0001_A05F);
        rd(12'h020); chk("R2 wide key stored masked", rd_a, 32'h0000_205F);
        mwr("R2 all ones", 12'h020, 32'hFFFF_FFFF);
        rd(12'h020); chk("R2 top bit forced low", rd_a, 32'h0000_7FFF);
        mwr("R2 key", 12'h020, 32'h0000_A05F);
        rd(12'h020); chk("R2 key stored", rd_a, 32'h0000_A05F);

        // R3 unlocked write with request, then pulse width
        mwr("R3 accepted req", 12'h040, 32'h0000_0155);
        @(posedge clk); #1;
        chk("R3 pulse one cycle", {31'h0, req_a}, 32'h0);
        rd(12'h040); chk("R3 level stored", rd_a, 32'h0000_0155);
        mwr("R3 accepted no req", 12'h040, 32'h0000_00AA);
        rd(12'h042); chk("R3 R9 low addr bits ignored", rd_a, 32'h0000_00AA);

        // R6 on the instance without reset control (same bus, unlocked)
        wr(12'h040, 32'h0000_01FF, ra, rb, rc);
        void'(model_wr('h010, 32'h0000_01FF));
        chk("R3 unlocked req", {31'h0, ra}, 32'h1);
        chk("R6 no request", {31'h0, rb}, 32'h0);
        rd(12'h040);
        chk("R6 reads zero", rd_b, 32'h0);
        rd(12'h000); chk("R8 id of second instance", rd_b, ID_NORL);

        // R3 locked write: unchanged, no pulse
        mwr("R2 relock", 12'h020, 32'h0000_1234);
        mwr("R3 locked no pulse", 12'h040, 32'h0000_0100);
        rd(12'h040); chk("R3 locked unchanged", rd_a, 32'h0000_01FF);

        // R7 protect bit position per board type
        card_det = 1'b1; card_wp = 1'b1;
        @(posedge clk);
        rd(12'h048);
        chk("R7 generic layout", rd_a, 32'h3);
        chk("R7 high layout", rd_c, 32'h5);
        card_det = 1'b0;
        @(posedge clk);
        rd(12'h048);
        chk("R7 high layout protect only", rd_c, 32'h4);
        mwr("R7 write ignored", 12'h048, 32'hFFFF_FFFF);
        rd(12'h048); chk("R7 write ignored", rd_a, 32'h2);

        // R1 R5 system reset keeps retained flags
        mwr("R5 set", 12'h038, 32'hF0F0_0001);
        mwr("R4 set", 12'h030, 32'h0000_FFFF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_sysrst();
        sweep_rd("R1 R5 after system reset");
        chk("R1 led pins cleared", led_a, 32'h0);

        // R1 power-on reset clears retained flags
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        m_nf = '0;
        rd(12'h038); chk("R1 retained cleared by power-on", rd_a, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule